// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

Two single-word mailboxes pass 36-bit words between port A and port B, which run on unrelated clocks. The forward box is loaded from port A and drained by port B. The return box is loaded from port B and drained by port A. Each port drives a write/read select (1 = write, 0 = read) and a mailbox select (1 = mailbox, 0 = the FIFO path). A word is written into the box that the port owns. A read returns either the box the port drains or the FIFO word presented on the port's FIFO input bus. The FIFO storage itself lives outside this block.

Every box has an active-low occupancy flag in each clock domain. The flag is 0 while a word is held. The writer-side flag drops on the edge that loads the word. It locks out further loads until the reader's drain has crossed back through a two-stage synchronizer. The reader-side flag shows the word only after the load has crossed the other way. Each flag is the XOR of two toggle registers, one owned by each clock. No register is driven by both clocks.

The read data and the output enable are registered. A port's output enable is the inverse of the write/read select from the previous edge of that port's clock. The enable stands in for a tri-state data pin.

Top module: `mbox_pair`

## Requirements
- R1: While `rst` is high at clock edges, all four flags read 1 (empty), and both `a_oe` and `b_oe` read 0. Both data outputs read 0 after the first reset edge of their own clock.
- R2: A rising `clk_a` edge with `a_wr`=1, `a_mbx`=1 and `a_fl_a2b_n`=1 loads `a_din` into the forward box. `a_fl_a2b_n` is 0 right after that edge.
- R3: A rising `clk_a` edge with `a_wr`=1 and `a_mbx`=1 while `a_fl_a2b_n`=0 changes nothing. The word later drained from the forward box is the word loaded before the flag dropped.
- R4: After a forward load, `b_fl_a2b_n` becomes 0 after the second rising `clk_b` edge that follows the loading edge.
- R5: A rising `clk_b` edge with `b_wr`=0, `b_mbx`=1 and `b_fl_a2b_n`=0 drains the forward box. The word is on `b_dout` after that edge, and `b_fl_a2b_n` is 1 after it. `a_fl_a2b_n` returns to 1 after the second rising `clk_a` edge that follows the draining edge.
- R6: The return box mirrors R2 to R5 with the ports swapped. It is loaded from `b_din` (flag `b_fl_b2a_n`), seen on port A through `a_fl_b2a_n`, and drained onto `a_dout`. A mailbox read on a port always puts that port's drained box word on its data output after the edge, even when the box is empty.
- R7: A rising edge of a port's clock with write/read select 0 and mailbox select 0 puts that port's FIFO input word on its data output after the edge.
- R8: After each rising edge of a port's clock, the port's output enable equals the inverse of the write/read select sampled at that edge. The data output holds its value across write edges.
- R9: Every accepted load is drained exactly once and in order. A mailbox read while the reader-side flag is 1 drains nothing and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| a_wr | input | 1 | Port A write/read select, 1 = write |
| a_mbx | input | 1 | Port A mailbox select, 1 = mailbox |
| a_din | input | 36 | Port A write data |
| a_fifo_q | input | 36 | FIFO word offered to port A reads |
| a_dout | output | 36 | Port A registered read data |
| a_oe | output | 1 | Port A output enable |
| a_fl_a2b_n | output | 1 | Forward box flag seen by port A, 0 = full |
| a_fl_b2a_n | output | 1 | Return box flag seen by port A, 0 = word waiting |
| b_wr | input | 1 | Port B write/read select, 1 = write |
| b_mbx | input | 1 | Port B mailbox select, 1 = mailbox |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | FIFO word offered to port B reads |
| b_dout | output | 36 | Port B registered read data |
| b_oe | output | 1 | Port B output enable |
| b_fl_a2b_n | output | 1 | Forward box flag seen by port B, 0 = word waiting |
| b_fl_b2a_n | output | 1 | Return box flag seen by port B, 0 = full |

## Verification
The writer-side flag drops on the loading edge itself. Data and enable outputs land one edge after the read. The reader-side flag, and the writer-side release, land on the second edge of the far clock after the causing edge. The bench model queues a countdown of two far-clock edges for each crossing event and applies it only after it has decided that edge's operations from the pre-edge state. Outputs are compared at the falling edge of their own clock. The two clocks are phased so that their rising edges never coincide, so every crossing has one defined synchronizer latency.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int unsigned MBOX_DW = 36;
  parameter int unsigned MBOX_SYNC = 2;

  typedef struct packed {
    logic load;
    logic drain;
  } mbox_req_t;

  function automatic mbox_req_t mbox_decode(input logic wr_sel, input logic mbx_sel);
    mbox_req_t r;
    r.load  = wr_sel & mbx_sel;
    r.drain = ~wr_sel & mbx_sel;
    return r;
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int unsigned DW     = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          load_req,
  input  logic [DW-1:0] wdata,
  output logic          w_full_n,
  input  logic          drain_req,
  output logic [DW-1:0] word_q,
  output logic          r_full_n
);
  logic wtog, rtog;
  logic rtog_w, wtog_r;
  logic w_full, r_full;
  logic load_ok, drain_ok;

  mbox_sync #(.STAGES(STAGES)) u_r2w (.clk(wclk), .rst(rst), .d(rtog), .q(rtog_w));
  mbox_sync #(.STAGES(STAGES)) u_w2r (.clk(rclk), .rst(rst), .d(wtog), .q(wtog_r));

  assign w_full   = wtog ^ rtog_w;
  assign r_full   = wtog_r ^ rtog;
  assign load_ok  = load_req & ~w_full;
  assign drain_ok = drain_req & r_full;

  // writer domain: toggle and word register
  always_ff @(posedge wclk) begin
    if (rst)          wtog <= 1'b0;
    else if (load_ok) wtog <= ~wtog;
  end

  always_ff @(posedge wclk) begin
    if (!rst && load_ok) word_q <= wdata;
  end

  // reader domain: toggle
  always_ff @(posedge rclk) begin
    if (rst)           rtog <= 1'b0;
    else if (drain_ok) rtog <= ~rtog;
  end

  assign w_full_n = ~w_full;
  assign r_full_n = ~r_full;
endmodule

// File: rtl/mbox_port_out.sv
module mbox_port_out #(
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_sel,
  input  logic          mbx_sel,
  input  logic [DW-1:0] mail_word,
  input  logic [DW-1:0] fifo_word,
  output logic [DW-1:0] dout,
  output logic          oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      dout <= '0;
    end else begin
      oe <= ~wr_sel;
      if (!wr_sel) dout <= mbx_sel ? mail_word : fifo_word;
    end
  end
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int unsigned DW     = MBOX_DW,
  parameter int unsigned STAGES = MBOX_SYNC
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst,
  input  logic          a_wr,
  input  logic          a_mbx,
  input  logic [DW-1:0] a_din,
  input  logic [DW-1:0] a_fifo_q,
  output logic [DW-1:0] a_dout,
  output logic          a_oe,
  output logic          a_fl_a2b_n,
  output logic          a_fl_b2a_n,
  input  logic          b_wr,
  input  logic          b_mbx,
  input  logic [DW-1:0] b_din,
  input  logic [DW-1:0] b_fifo_q,
  output logic [DW-1:0] b_dout,
  output logic          b_oe,
  output logic          b_fl_a2b_n,
  output logic          b_fl_b2a_n
);
  mbox_req_t req_a, req_b;
  logic [DW-1:0] a2b_word, b2a_word;

  assign req_a = mbox_decode(a_wr, a_mbx);
  assign req_b = mbox_decode(b_wr, b_mbx);

  mbox_slot #(.DW(DW), .STAGES(STAGES)) u_a2b (
    .wclk(clk_a), .rclk(clk_b), .rst(rst),
    .load_req(req_a.load), .wdata(a_din), .w_full_n(a_fl_a2b_n),
    .drain_req(req_b.drain), .word_q(a2b_word), .r_full_n(b_fl_a2b_n)
  );

  mbox_slot #(.DW(DW), .STAGES(STAGES)) u_b2a (
    .wclk(clk_b), .rclk(clk_a), .rst(rst),
    .load_req(req_b.load), .wdata(b_din), .w_full_n(b_fl_b2a_n),
    .drain_req(req_a.drain), .word_q(b2a_word), .r_full_n(a_fl_b2a_n)
  );

  mbox_port_out #(.DW(DW)) u_out_a (
    .clk(clk_a), .rst(rst), .wr_sel(a_wr), .mbx_sel(a_mbx),
    .mail_word(b2a_word), .fifo_word(a_fifo_q), .dout(a_dout), .oe(a_oe)
  );

  mbox_port_out #(.DW(DW)) u_out_b (
    .clk(clk_b), .rst(rst), .wr_sel(b_wr), .mbx_sel(b_mbx),
    .mail_word(a2b_word), .fifo_word(b_fifo_q), .dout(b_dout), .oe(b_oe)
  );
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int unsigned DW = 36
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst,
  input logic          a_wr,
  input logic          a_mbx,
  input logic          b_wr,
  input logic          b_mbx,
  input logic [DW-1:0] a_fifo_q,
  input logic [DW-1:0] b_fifo_q,
  input logic [DW-1:0] a_dout,
  input logic [DW-1:0] b_dout,
  input logic          a_oe,
  input logic          b_oe,
  input logic          a_fl_a2b_n,
  input logic          a_fl_b2a_n,
  input logic          b_fl_a2b_n,
  input logic          b_fl_b2a_n,
  input logic [DW-1:0] a2b_word,
  input logic [DW-1:0] b2a_word
);
  p_load_drops_flag_r2: assert property (@(posedge clk_a) disable iff (rst)
    (a_wr && a_mbx && a_fl_a2b_n) |=> !a_fl_a2b_n);

  p_blocked_keeps_word_r3: assert property (@(posedge clk_a) disable iff (rst)
    (a_wr && a_mbx && !a_fl_a2b_n) |=> $stable(a2b_word));

  p_drain_frees_r5: assert property (@(posedge clk_b) disable iff (rst)
    (!b_wr && b_mbx && !b_fl_a2b_n) |=> b_fl_a2b_n);

  p_drain_data_r5: assert property (@(posedge clk_b) disable iff (rst)
    (!b_wr && b_mbx) |=> (b_dout == $past(a2b_word)));

  p_load_drops_flag_r6: assert property (@(posedge clk_b) disable iff (rst)
    (b_wr && b_mbx && b_fl_b2a_n) |=> !b_fl_b2a_n);

  p_drain_frees_r6: assert property (@(posedge clk_a) disable iff (rst)
    (!a_wr && a_mbx && !a_fl_b2a_n) |=> a_fl_b2a_n);

  p_fifo_path_r7: assert property (@(posedge clk_a) disable iff (rst)
    (!a_wr && !a_mbx) |=> (a_dout == $past(a_fifo_q)));

  p_fifo_path_b_r7: assert property (@(posedge clk_b) disable iff (rst)
    (!b_wr && !b_mbx) |=> (b_dout == $past(b_fifo_q)));

  p_oe_off_on_write_r8: assert property (@(posedge clk_b) disable iff (rst)
    b_wr |=> (!b_oe && $stable(b_dout)));

  p_oe_on_read_r8: assert property (@(posedge clk_a) disable iff (rst)
    !a_wr |=> a_oe);

  p_empty_read_idle_r9: assert property (@(posedge clk_b) disable iff (rst)
    (!b_wr && b_mbx && b_fl_a2b_n && a_fl_a2b_n) |=> b_fl_a2b_n);
endmodule

bind mbox_pair mbox_pair_chk #(.DW(DW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
  .a_wr(a_wr), .a_mbx(a_mbx), .b_wr(b_wr), .b_mbx(b_mbx),
  .a_fifo_q(a_fifo_q), .b_fifo_q(b_fifo_q),
  .a_dout(a_dout), .b_dout(b_dout), .a_oe(a_oe), .b_oe(b_oe),
  .a_fl_a2b_n(a_fl_a2b_n), .a_fl_b2a_n(a_fl_b2a_n),
  .b_fl_a2b_n(b_fl_a2b_n), .b_fl_b2a_n(b_fl_b2a_n),
  .a2b_word(u_a2b.word_q), .b2a_word(u_b2a.word_q)
);

// File: tb/mbox_pair_tb.sv
module mbox_pair_tb;
  localparam int DW           = 36;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int CLK_B_OFFSET = 2;
  localparam int A_CYCLES     = 3000;
  localparam int B_CYCLES     = 2200;
  localparam int WD_CYCLES    = 100000;

  logic clk_a = 1'b0, clk_b = 1'b0, rst = 1'b1;
  logic a_wr = 1'b1, a_mbx = 1'b0, b_wr = 1'b1, b_mbx = 1'b0;
  logic [DW-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
  logic [DW-1:0] a_dout, b_dout;
  logic a_oe, b_oe, a_fl_a2b_n, a_fl_b2a_n, b_fl_a2b_n, b_fl_b2a_n;

  mbox_pair u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
    .a_wr(a_wr), .a_mbx(a_mbx), .a_din(a_din), .a_fifo_q(a_fifo_q),
    .a_dout(a_dout), .a_oe(a_oe), .a_fl_a2b_n(a_fl_a2b_n), .a_fl_b2a_n(a_fl_b2a_n),
    .b_wr(b_wr), .b_mbx(b_mbx), .b_din(b_din), .b_fifo_q(b_fifo_q),
    .b_dout(b_dout), .b_oe(b_oe), .b_fl_a2b_n(b_fl_a2b_n), .b_fl_b2a_n(b_fl_b2a_n)
  );

  // rising edges: A at odd times, B at even times, never together
  initial forever #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  initial begin
    #(CLK_B_OFFSET);
    forever begin
      clk_b = 1'b1; #(CLK_B_PERIOD/2);
      clk_b = 1'b0; #(CLK_B_PERIOD/2);
    end
  end

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit live_a = 0, live_b = 0;
  bit m_a2b_wfull = 0, m_a2b_rfull = 0, m_b2a_wfull = 0, m_b2a_rfull = 0;
  bit a2b_seen = 0, b2a_seen = 0, a2b_blk = 0, b2a_blk = 0;
  logic [DW-1:0] m_a2b_word = '0, m_b2a_word = '0;
  int vis_a2b[$], rel_a2b[$], vis_b2a[$], rel_b2a[$];
  logic [DW-1:0] sb_a2b[$], sb_b2a[$];
  int n_load_a2b = 0, n_load_b2a = 0, n_take_a2b = 0, n_take_b2a = 0, n_blocked = 0;
  int n_empty_rd = 0;
  bit ea_oe = 0, eb_oe = 0, ea_chk = 0, eb_chk = 0;
  logic [DW-1:0] ea_dout = '0, eb_dout = '0;
  string ea_tag = "R1", eb_tag = "R1";

  always @(posedge clk_a) begin
    bit acc, take;
    if (rst) begin
      m_a2b_wfull = 0; m_b2a_rfull = 0;
      rel_a2b.delete(); vis_b2a.delete(); sb_b2a.delete();
      ea_oe = 0; ea_dout = '0; ea_chk = 1; ea_tag = "R1"; live_a = 1;
    end else begin
      acc  = a_wr && a_mbx && !m_a2b_wfull;
      take = !a_wr && a_mbx && m_b2a_rfull && (sb_b2a.size() > 0);
      if (a_wr && a_mbx && m_a2b_wfull) begin n_blocked++; a2b_blk = 1; end
      if (!a_wr && a_mbx && !m_b2a_rfull) n_empty_rd++;
      ea_oe = !a_wr;
      if (!a_wr) begin
        if (a_mbx) begin
          ea_dout = take ? sb_b2a[0] : m_b2a_word;
          ea_chk  = take || b2a_seen;
          ea_tag  = take ? (b2a_blk ? "R3" : "R9") : "R6";
        end else begin
          ea_dout = a_fifo_q; ea_chk = 1; ea_tag = "R7";
        end
      end else ea_tag = "R8";
      for (int i = 0; i < rel_a2b.size(); i++) rel_a2b[i]--;
      while (rel_a2b.size() > 0 && rel_a2b[0] == 0) begin
        void'(rel_a2b.pop_front()); m_a2b_wfull = 0;
      end
      for (int i = 0; i < vis_b2a.size(); i++) vis_b2a[i]--;
      while (vis_b2a.size() > 0 && vis_b2a[0] == 0) begin
        void'(vis_b2a.pop_front()); m_b2a_rfull = 1;
      end
      if (acc) begin
        m_a2b_wfull = 1; m_a2b_word = a_din; a2b_seen = 1; a2b_blk = 0;
        vis_a2b.push_back(2); sb_a2b.push_back(a_din); n_load_a2b++;
      end
      if (take) begin
        m_b2a_rfull = 0; rel_b2a.push_back(2);
        void'(sb_b2a.pop_front()); n_take_b2a++;
      end
    end
  end

  always @(posedge clk_b) begin
    bit acc, take;
    if (rst) begin
      m_b2a_wfull = 0; m_a2b_rfull = 0;
      rel_b2a.delete(); vis_a2b.delete(); sb_a2b.delete();
      eb_oe = 0; eb_dout = '0; eb_chk = 1; eb_tag = "R1"; live_b = 1;
    end else begin
      acc  = b_wr && b_mbx && !m_b2a_wfull;
      take = !b_wr && b_mbx && m_a2b_rfull && (sb_a2b.size() > 0);
      if (b_wr && b_mbx && m_b2a_wfull) begin n_blocked++; b2a_blk = 1; end
      if (!b_wr && b_mbx && !m_a2b_rfull) n_empty_rd++;
      eb_oe = !b_wr;
      if (!b_wr) begin
        if (b_mbx) begin
          eb_dout = take ? sb_a2b[0] : m_a2b_word;
          eb_chk  = take || a2b_seen;
          eb_tag  = take ? (a2b_blk ? "R3" : "R9") : "R5";
        end else begin
          eb_dout = b_fifo_q; eb_chk = 1; eb_tag = "R7";
        end
      end else eb_tag = "R8";
      for (int i = 0; i < rel_b2a.size(); i++) rel_b2a[i]--;
      while (rel_b2a.size() > 0 && rel_b2a[0] == 0) begin
        void'(rel_b2a.pop_front()); m_b2a_wfull = 0;
      end
      for (int i = 0; i < vis_a2b.size(); i++) vis_a2b[i]--;
      while (vis_a2b.size() > 0 && vis_a2b[0] == 0) begin
        void'(vis_a2b.pop_front()); m_a2b_rfull = 1;
      end
      if (acc) begin
        m_b2a_wfull = 1; m_b2a_word = b_din; b2a_seen = 1; b2a_blk = 0;
        vis_b2a.push_back(2); sb_b2a.push_back(b_din); n_load_b2a++;
      end
      if (take) begin
        m_a2b_rfull = 0; rel_a2b.push_back(2);
        void'(sb_a2b.pop_front()); n_take_a2b++;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk_a) if (live_a && !done) begin
    check(a_fl_a2b_n == !m_a2b_wfull, rst ? "R1" : (m_a2b_wfull ? "R2" : "R5"),
          DW'(a_fl_a2b_n), DW'(!m_a2b_wfull));
    check(a_fl_b2a_n == !m_b2a_rfull, rst ? "R1" : "R6", DW'(a_fl_b2a_n), DW'(!m_b2a_rfull));
    check(a_oe == ea_oe, rst ? "R1" : "R8", DW'(a_oe), DW'(ea_oe));
    if (ea_chk) check(a_dout == ea_dout, ea_tag, a_dout, ea_dout);
  end

  always @(negedge clk_b) if (live_b && !done) begin
    check(b_fl_a2b_n == !m_a2b_rfull, rst ? "R1" : "R4", DW'(b_fl_a2b_n), DW'(!m_a2b_rfull));
    check(b_fl_b2a_n == !m_b2a_wfull, rst ? "R1" : "R6", DW'(b_fl_b2a_n), DW'(!m_b2a_wfull));
    check(b_oe == eb_oe, rst ? "R1" : "R8", DW'(b_oe), DW'(eb_oe));
    if (eb_chk) check(b_dout == eb_dout, eb_tag, b_dout, eb_dout);
  end

  // ---------------- stimulus ----------------
  task automatic drive_a(input int n);
    repeat (n) begin
      @(negedge clk_a);
      a_wr     = 1'($urandom_range(0, 1));
      a_mbx    = ($urandom_range(0, 2) != 0);
      a_din    = DW'({$urandom(), $urandom()});
      a_fifo_q = DW'({$urandom(), $urandom()});
    end
  endtask

  task automatic drive_b(input int n);
    repeat (n) begin
      @(negedge clk_b);
      b_wr     = 1'($urandom_range(0, 1));
      b_mbx    = ($urandom_range(0, 2) != 0);
      b_din    = DW'({$urandom(), $urandom()});
      b_fifo_q = DW'({$urandom(), $urandom()});
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_a);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (6) @(posedge clk_b);
    @(negedge clk_a);
    // R1: flags empty and enables off during reset
    check(a_fl_a2b_n && a_fl_b2a_n && b_fl_a2b_n && b_fl_b2a_n, "R1",
          DW'({a_fl_a2b_n, a_fl_b2a_n, b_fl_a2b_n, b_fl_b2a_n}), DW'(4'hF));
    check(!a_oe && !b_oe, "R1", DW'({a_oe, b_oe}), '0);
    rst = 1'b0;
    fork
      drive_a(A_CYCLES);
      drive_b(B_CYCLES);
    join
    // drain both boxes with no new loads
    fork
      begin @(negedge clk_a); a_wr = 1'b0; a_mbx = 1'b1; end
      begin @(negedge clk_b); b_wr = 1'b0; b_mbx = 1'b1; end
    join
    repeat (30) @(posedge clk_b);
    fork
      begin @(negedge clk_a); a_wr = 1'b1; a_mbx = 1'b0; end
      begin @(negedge clk_b); b_wr = 1'b1; b_mbx = 1'b0; end
    join
    repeat (10) @(posedge clk_b);
    @(negedge clk_a);
    // R9: each load drained exactly once, nothing left over
    check(n_take_a2b == n_load_a2b && sb_a2b.size() == 0, "R9", DW'(n_take_a2b), DW'(n_load_a2b));
    check(n_take_b2a == n_load_b2a && sb_b2a.size() == 0, "R9", DW'(n_take_b2a), DW'(n_load_b2a));
    check(n_load_a2b > 20 && n_load_b2a > 20, "R2", DW'(n_load_a2b), DW'(21));
    check(n_blocked > 0, "R3", DW'(n_blocked), DW'(1));
    check(n_empty_rd > 0, "R9", DW'(n_empty_rd), DW'(1));
    check(a_fl_a2b_n && a_fl_b2a_n && b_fl_a2b_n && b_fl_b2a_n, "R9",
          DW'({a_fl_a2b_n, a_fl_b2a_n, b_fl_a2b_n, b_fl_b2a_n}), DW'(4'hF));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule